// File: doc/BRIEF.md
# Buck Converter Switch-Sequencing Controller

This block sequences the two power switches of a synchronous buck stage. It drives an enable for the high-side switch (charging) and one for the low-side switch (freewheeling). It reacts to three comparator flags: supply too low, inductor current too high, and inductor current crossing zero. Two acknowledge inputs report when each power transistor has actually crossed its threshold. Every change of a gate output waits for the matching acknowledge to catch up, so the sequencing tracks the real switching delay of the large output devices and needs no fixed dead-time counter.

All five inputs pass through a synchronizer chain of `SYNC_STAGES` flops. The under-voltage and zero-crossing flags are edge-captured into pending requests, so an event that arrives during a handshake is served once that handshake completes. The over-current flag is a level that has meaning only while the high side is fully on. A 3-bit phase output shows the state machine's current phase for debug.

Phases (with `phase_o` code): LS_ON (0), low side on and idle; LS_FALL (1), low side turning off; HS_RISE (2), high side turning on; HS_ON (3), high side on; HS_FALL (4), high side turning off; LS_RISE (5), low side turning on; ALL_OFF (6), both off after an early zero-crossing. Transitions: LS_ON→LS_FALL on an under-voltage or zero-crossing request. LS_FALL→HS_RISE once the low-side acknowledge is low and a charge is requested. LS_FALL→ALL_OFF once the low-side acknowledge is low and no charge is requested. ALL_OFF→HS_RISE on an under-voltage request. HS_RISE→HS_ON once the high-side acknowledge is high. HS_ON→HS_FALL on over-current. HS_FALL→LS_RISE once the high-side acknowledge is low. LS_RISE→LS_ON once the low-side acknowledge is high.

Top module: `buck_seq_ctrl`

## Requirements
- R1: Sampling `rst_n` low at a clock edge forces `gn_o`=1, `gp_o`=0 and `phase_o`=0 (LS_ON). The phase codes are LS_ON=0, LS_FALL=1, HS_RISE=2, HS_ON=3, HS_FALL=4, LS_RISE=5, ALL_OFF=6.
- R2: In LS_ON, a rise of `uv_i` drives `gn_o` low and `phase_o` to 1 on the (SYNC_STAGES+1)-th clock edge after the rise, and not earlier.
- R3: `gp_o` stays low while the low-side acknowledge is still high. It rises, with `phase_o`=2, SYNC_STAGES+1 edges after `gn_ack_i` falls. `phase_o` becomes 3 SYNC_STAGES+1 edges after `gp_ack_i` rises.
- R4: In HS_ON, `oc_i` high drives `gp_o` low with `phase_o`=4 SYNC_STAGES+1 edges later. `gn_o` stays low until `gp_ack_i` falls, then rises with `phase_o`=5 SYNC_STAGES+1 edges later. `phase_o` returns to 0 SYNC_STAGES+1 edges after `gn_ack_i` rises.
- R5: `oc_i` has no effect in any phase other than HS_ON.
- R6: A `zc_i` rise in LS_ON turns the low side off with R2's latency. If no charge is pending when `gn_ack_i` falls, `phase_o` becomes 6 with both gates low. It stays there until a `uv_i` rise, which raises `gp_o` SYNC_STAGES+1 edges later.
- R7: A zero-crossing rise that occurs during an under-voltage turn-off or a charge phase (phases 1 to 4 of a charge) is discarded. It causes no low-side turn-off after the controller returns to LS_ON.
- R8: A `uv_i` rise during a zero-crossing turn-off (phase 1) is held. When `gn_ack_i` falls, the controller goes to HS_RISE instead of ALL_OFF.
- R9: A `zc_i` rise during LS_RISE is held. The controller spends exactly one cycle in LS_ON, then enters LS_FALL.
- R10: `gp_o` and `gn_o` are never high together. `gp_o` is high only while the synchronized low-side acknowledge is low, and `gn_o` is high only while the synchronized high-side acknowledge is low.
- R11: A gate output changes only when its synchronized acknowledge already equals the gate's current value, which completes each four-phase handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uv_i | input | 1 | Under-voltage comparator flag (asynchronous) |
| oc_i | input | 1 | Over-current comparator flag (asynchronous) |
| zc_i | input | 1 | Zero-crossing comparator flag (asynchronous) |
| gp_ack_i | input | 1 | High-side switch has crossed its threshold |
| gn_ack_i | input | 1 | Low-side switch has crossed its threshold |
| gp_o | output | 1 | High-side gate enable |
| gn_o | output | 1 | Low-side gate enable |
| phase_o | output | 3 | Current phase code (see R1) |

## Verification
The bench builds the block with its default of two synchronizer stages. Every reaction therefore lands exactly three edges after its stimulus, and the bench pins that latency by checking one cycle before and on the edge itself. It plays the power stage by hand, holding each acknowledge back for several cycles. This shows that a gate waits for its handshake. It also places comparator pulses inside specific handshake windows, which reaches the held and discarded request cases of R7 to R9. A reset issued in the middle of a charge confirms the forced start state.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;

    localparam int PHASE_W = 3;

    typedef enum logic [PHASE_W-1:0] {
        PH_LS_ON   = 3'd0,
        PH_LS_FALL = 3'd1,
        PH_HS_RISE = 3'd2,
        PH_HS_ON   = 3'd3,
        PH_HS_FALL = 3'd4,
        PH_LS_RISE = 3'd5,
        PH_ALL_OFF = 3'd6
    } phase_t;

    // bit positions inside the synchronized input vector
    localparam int IN_UV  = 0;
    localparam int IN_OC  = 1;
    localparam int IN_ZC  = 2;
    localparam int IN_GPA = 3;
    localparam int IN_GNA = 4;
    localparam int IN_W   = 5;

    // values the synchronizer holds in reset: only the low-side ack is high
    localparam logic [IN_W-1:0] IN_RST = 5'b10000;

endpackage

// File: rtl/buck_sync.sv
module buck_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
        end else begin
            chain[0] <= d_i;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/buck_req_hold.sv
module buck_req_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,     // synchronized flag level
    input  logic clr_i,     // consume or discard
    output logic req_o      // live request: held or arriving now
);

    logic lvl_prev;
    logic pend_q;
    logic rise;

    assign rise  = lvl_i & ~lvl_prev;
    assign req_o = pend_q | rise;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_prev <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            lvl_prev <= lvl_i;
            pend_q   <= (pend_q | rise) & ~clr_i;
        end
    end

endmodule

// File: rtl/buck_phase_fsm.sv
module buck_phase_fsm
    import buck_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               uv_req_i,
    input  logic               zc_req_i,
    input  logic               oc_lvl_i,
    input  logic               gp_ack_s_i,
    input  logic               gn_ack_s_i,
    output logic               uv_take_o,
    output logic               zc_clr_o,
    output logic               gp_o,
    output logic               gn_o,
    output logic [PHASE_W-1:0] phase_o
);

    phase_t state_q, state_d;
    logic   gp_q, gn_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_LS_ON;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_LS_ON:   if (uv_req_i || zc_req_i) state_d = PH_LS_FALL;
            PH_LS_FALL: if (!gn_ack_s_i)          state_d = uv_req_i ? PH_HS_RISE : PH_ALL_OFF;
            PH_HS_RISE: if (gp_ack_s_i)           state_d = PH_HS_ON;
            PH_HS_ON:   if (oc_lvl_i)             state_d = PH_HS_FALL;
            PH_HS_FALL: if (!gp_ack_s_i)          state_d = PH_LS_RISE;
            PH_LS_RISE: if (gn_ack_s_i)           state_d = PH_LS_ON;
            PH_ALL_OFF: if (uv_req_i)             state_d = PH_HS_RISE;
            default:                              state_d = PH_LS_ON;
        endcase
    end

    // request bookkeeping toward the hold registers
    always_comb begin
        uv_take_o = (state_d == PH_HS_RISE) && (state_q != PH_HS_RISE);
        zc_clr_o  = ((state_q == PH_LS_ON) && (state_d == PH_LS_FALL))
                 || (state_q == PH_HS_RISE)
                 || (state_q == PH_HS_ON)
                 || (state_q == PH_HS_FALL);
    end

    // registered gate outputs decoded from the next phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gp_q <= 1'b0;
            gn_q <= 1'b1;
        end else begin
            gp_q <= (state_d == PH_HS_RISE) || (state_d == PH_HS_ON);
            gn_q <= (state_d == PH_LS_ON)   || (state_d == PH_LS_RISE);
        end
    end

    assign gp_o    = gp_q;
    assign gn_o    = gn_q;
    assign phase_o = state_q;

    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !(gp_q && gn_q)); // R10
    AST_GP_NEEDS_LS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        gp_q |-> !gn_ack_s_i); // R10
    AST_GN_NEEDS_HS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        gn_q |-> !gp_ack_s_i); // R10
    AST_GP_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gp_q) |-> ($past(gp_ack_s_i) == $past(gp_q))); // R11
    AST_GN_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gn_q) |-> ($past(gn_ack_s_i) == $past(gn_q))); // R11
    AST_OC_ONLY_IN_HS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gp_q) |-> ($past(state_q) == PH_HS_ON) && $past(oc_lvl_i)); // R5
    AST_CHARGE_NEEDS_UV: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gp_q) |-> $past(uv_req_i)); // R6
    AST_ALL_OFF_GATES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_ALL_OFF) |-> (!gp_q && !gn_q)); // R6

endmodule

// File: rtl/buck_seq_ctrl.sv
module buck_seq_ctrl
    import buck_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               uv_i,
    input  logic               oc_i,
    input  logic               zc_i,
    input  logic               gp_ack_i,
    input  logic               gn_ack_i,
    output logic               gp_o,
    output logic               gn_o,
    output logic [PHASE_W-1:0] phase_o
);

    logic [IN_W-1:0] raw_in, syn_in;
    logic uv_req, zc_req, uv_take, zc_clr;

    always_comb begin
        raw_in         = '0;
        raw_in[IN_UV]  = uv_i;
        raw_in[IN_OC]  = oc_i;
        raw_in[IN_ZC]  = zc_i;
        raw_in[IN_GPA] = gp_ack_i;
        raw_in[IN_GNA] = gn_ack_i;
    end

    buck_sync #(
        .STAGES  (SYNC_STAGES),
        .WIDTH   (IN_W),
        .RST_VAL (IN_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (syn_in)
    );

    buck_req_hold u_uv_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (syn_in[IN_UV]),
        .clr_i (uv_take),
        .req_o (uv_req)
    );

    buck_req_hold u_zc_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (syn_in[IN_ZC]),
        .clr_i (zc_clr),
        .req_o (zc_req)
    );

    buck_phase_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .uv_req_i   (uv_req),
        .zc_req_i   (zc_req),
        .oc_lvl_i   (syn_in[IN_OC]),
        .gp_ack_s_i (syn_in[IN_GPA]),
        .gn_ack_s_i (syn_in[IN_GNA]),
        .uv_take_o  (uv_take),
        .zc_clr_o   (zc_clr),
        .gp_o       (gp_o),
        .gn_o       (gn_o),
        .phase_o    (phase_o)
    );

    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o != 3'd7); // R1

endmodule

// File: tb/tb_buck_seq_ctrl.sv
module tb_buck_seq_ctrl;

    localparam int CLK_P = 10;
    localparam int LAT   = 3;   // SYNC_STAGES + 1 with the default build

    logic clk = 1'b0;
    logic rst_n, uv, oc, zc, gp_ack, gn_ack;
    logic gp, gn;
    logic [2:0] ph;

    int checks = 0;
    int fails  = 0;
    int overlap = 0;
    int hs_viol = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    buck_seq_ctrl #(.SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .uv_i(uv), .oc_i(oc), .zc_i(zc),
        .gp_ack_i(gp_ack), .gn_ack_i(gn_ack),
        .gp_o(gp), .gn_o(gn), .phase_o(ph)
    );

    // port-level monitors for R10 and R11
    logic last_gp = 1'b0, last_gn = 1'b1, last_gpa = 1'b0, last_gna = 1'b1;
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (gp && gn) overlap++;
            if (gp !== last_gp && last_gpa !== last_gp) hs_viol++;
            if (gn !== last_gn && last_gna !== last_gn) hs_viol++;
        end
        last_gp = gp; last_gn = gn; last_gpa = gp_ack; last_gna = gn_ack;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d (time %0t)", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // LS_ON -> HS_ON through a full handshake
    task automatic charge(input string req);
        uv = 1'b1; step(LAT); chk({req, " to LS_FALL"}, ph, 1);
        uv = 1'b0;
        gn_ack = 1'b0; step(LAT); chk({req, " to HS_RISE"}, ph, 2);
        gp_ack = 1'b1; step(LAT); chk({req, " to HS_ON"}, ph, 3);
    endtask

    // HS_ON -> LS_ON through a full handshake
    task automatic discharge(input string req);
        oc = 1'b1; step(LAT); chk({req, " to HS_FALL"}, ph, 4);
        gp_ack = 1'b0; step(LAT); chk({req, " to LS_RISE"}, ph, 5);
        oc = 1'b0;
        gn_ack = 1'b1; step(LAT); chk({req, " to LS_ON"}, ph, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; uv = 0; oc = 0; zc = 0; gp_ack = 0; gn_ack = 1;
        step(3);
        chk("R1 gn after reset", gn, 1);
        chk("R1 gp after reset", gp, 0);
        chk("R1 phase after reset", ph, 0);
        rst_n = 1'b1; step(2);
    endtask

    task automatic t_no_zc();
        uv = 1'b1; step(LAT-1);
        chk("R2 gn not early", gn, 1);
        step(1);
        chk("R2 gn low", gn, 0);
        chk("R2 phase LS_FALL", ph, 1);
        uv = 1'b0; step(5);
        chk("R3 gp held for gn_ack", gp, 0);
        gn_ack = 1'b0; step(LAT-1);
        chk("R3 gp not early", gp, 0);
        step(1);
        chk("R3 gp high", gp, 1);
        chk("R3 phase HS_RISE", ph, 2);
        gp_ack = 1'b1; step(LAT);
        chk("R3 phase HS_ON", ph, 3);
        oc = 1'b1; step(LAT-1);
        chk("R4 gp not early", gp, 1);
        step(1);
        chk("R4 gp low", gp, 0);
        chk("R4 phase HS_FALL", ph, 4);
        step(5);
        chk("R4 gn held for gp_ack", gn, 0);
        gp_ack = 1'b0; step(LAT);
        chk("R4 gn high", gn, 1);
        chk("R4 phase LS_RISE", ph, 5);
        oc = 1'b0;
        gn_ack = 1'b1; step(LAT);
        chk("R4 phase LS_ON", ph, 0);
    endtask

    task automatic t_oc_ignored();
        oc = 1'b1; step(6);
        chk("R5 oc in LS_ON phase", ph, 0);
        chk("R5 oc in LS_ON gn", gn, 1);
        oc = 1'b0; step(4);
    endtask

    task automatic t_early_zc();
        zc = 1'b1; step(LAT);
        chk("R6 zc lowers gn", gn, 0);
        chk("R6 zc phase LS_FALL", ph, 1);
        zc = 1'b0;
        gn_ack = 1'b0; step(LAT);
        chk("R6 phase ALL_OFF", ph, 6);
        oc = 1'b1; step(5); oc = 1'b0; step(5);
        chk("R5 oc in ALL_OFF phase", ph, 6);
        chk("R6 gp stays low", gp, 0);
        chk("R6 gn stays low", gn, 0);
        uv = 1'b1; step(LAT);
        chk("R6 uv raises gp", gp, 1);
        uv = 1'b0;
        gp_ack = 1'b1; step(LAT);
        chk("R6 phase HS_ON", ph, 3);
        discharge("R6");
    endtask

    task automatic t_late_zc();
        uv = 1'b1; step(LAT); chk("R7 phase LS_FALL", ph, 1);
        uv = 1'b0;
        zc = 1'b1; step(3); zc = 1'b0;
        gn_ack = 1'b0; step(LAT); chk("R7 still charges", ph, 2);
        gp_ack = 1'b1; step(LAT); chk("R7 phase HS_ON", ph, 3);
        discharge("R7");
        step(10);
        chk("R7 late zc discarded phase", ph, 0);
        chk("R7 late zc discarded gn", gn, 1);
    endtask

    task automatic t_held_uv();
        zc = 1'b1; step(LAT); chk("R8 zc phase LS_FALL", ph, 1);
        zc = 1'b0;
        uv = 1'b1; step(3); uv = 1'b0; step(3);
        gn_ack = 1'b0; step(LAT);
        chk("R8 held uv phase HS_RISE", ph, 2);
        chk("R8 held uv gp", gp, 1);
        gp_ack = 1'b1; step(LAT);
        discharge("R8");
    endtask

    task automatic t_held_zc();
        charge("R9");
        oc = 1'b1; step(LAT); chk("R9 phase HS_FALL", ph, 4);
        gp_ack = 1'b0; step(LAT); chk("R9 phase LS_RISE", ph, 5);
        oc = 1'b0;
        zc = 1'b1; step(3); zc = 1'b0; step(2);
        chk("R9 zc waits in LS_RISE", ph, 5);
        gn_ack = 1'b1; step(LAT);
        chk("R9 one cycle of LS_ON", ph, 0);
        step(1);
        chk("R9 held zc phase LS_FALL", ph, 1);
        chk("R9 held zc gn", gn, 0);
        gn_ack = 1'b0; step(LAT);
        chk("R9 phase ALL_OFF", ph, 6);
        uv = 1'b1; step(LAT); uv = 1'b0;
        gp_ack = 1'b1; step(LAT);
        discharge("R9");
    endtask

    task automatic t_reset_mid();
        charge("R1 mid");
        rst_n = 1'b0; gp_ack = 1'b0; gn_ack = 1'b1;
        step(1);
        chk("R1 mid reset gn", gn, 1);
        chk("R1 mid reset gp", gp, 0);
        chk("R1 mid reset phase", ph, 0);
        step(2);
        rst_n = 1'b1; step(LAT);
        chk("R1 after mid reset phase", ph, 0);
    endtask

    initial begin
        t_reset();
        t_no_zc();
        t_oc_ignored();
        t_early_zc();
        t_late_zc();
        t_held_uv();
        t_held_zc();
        t_reset_mid();
        chk("R10 overlap cycles", overlap, 0);
        chk("R11 handshake violations", hs_viol, 0);
        summary();
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
            summary();
        end
    end

endmodule